// File: doc/BRIEF.md
# Debug Cross-Trigger Interface

This block sits between a local group of debug event sources and sinks and a shared set of broadcast event channels that a hub distributes among many such interfaces. Trigger inputs are synchronized, then mapped through per-input masks onto any combination of the four channels. Those events leave the block on the channel-out lines. Events from other interfaces arrive on the channel-in lines. Per-output masks select which channels assert each of the eight registered trigger outputs.

Locally generated channel events are also looped back into the output mapping, so one interface can route a trigger from one local input to one of its own outputs without a hub. A block register stops chosen channels on the outbound side without touching any mapping. Software can also inject a one-cycle event on any channel. All configuration goes through a plain word-addressed register port with single-cycle writes and combinational reads.

Top module: `dbg_xtrig_link`

## Requirements
- R1: After reset, every register reads 0 and `chan_out` and `trig_out` are 0. With all masks at 0, no input reaches any channel or output.
- R2: Register `IMAP[i]` sits at byte offset 0x20+4*i and holds bits [3:0], where bit c selects channel c. While the global enable is set and `trig_in[i]` is high, `chan_out` carries the OR of the `IMAP` masks of all high inputs. An input with a zero mask drives nothing.
- R3: Register `OMAP[j]` sits at byte offset 0x40+4*j and holds bits [3:0], where bit c selects channel c. `trig_out[j]` goes high one clock after any selected channel is active on `chan_in` or on `chan_out` (loopback).
- R4: A level change on `trig_in` first shows on `chan_out` after the second rising clock edge. It shows on `trig_out` after the third edge, and not earlier.
- R5: Register `CBLK` sits at offset 0x04, bits [3:0]. A 1 in bit c forces channel c low on `chan_out` and in the loopback path. Writing `CBLK` leaves every `IMAP` and `OMAP` value unchanged.
- R6: A write to offset 0x08 drives the written bits [3:0] on `chan_out` for exactly the one cycle after the write edge, subject to `CBLK` and the global enable. This offset reads back 0.
- R7: Register `CTRL` sits at offset 0x00, and its bit 0 is the global enable. While it is clear, `chan_out` is 0 at once. `trig_out` is 0 from the next clock edge on.
- R8: All defined registers read back the last value written. Writes to any other offset change no register, and reads from such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 8 | Asynchronous trigger inputs from local debug sources |
| chan_in | input | 4 | Channel events arriving from the hub |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| chan_out | output | 4 | Channel events sent toward the hub |
| trig_out | output | 8 | Registered trigger outputs to local debug sinks |

## Verification
Corrupted mask state shows at the ports as a wrong channel pattern on `chan_out` two edges after a steady trigger input is applied, and as a wrong `trig_out` pattern one edge later. A stuck pulse register would hold `chan_out` high for a second cycle after a pulse write. A block register that clobbers mappings would show as changed `IMAP` or `OMAP` readback after a `CBLK` write. Because loopback feeds the output mapping, a single configuration exposes both mask sets in the same vector.

// File: rtl/dbg_xtrig_link.sv
module dbg_xtrig_link #(
  parameter int N_TRIG = 8,
  parameter int N_CHAN = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [N_CHAN-1:0] chan_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_CHAN-1:0] chan_out,
  output logic [N_TRIG-1:0] trig_out
);

  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_CBLK  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_PULSE = ADDR_W'(8'h08);
  localparam int               OFS_IMAP  = 'h20;
  localparam int               OFS_OMAP  = 'h40;

  logic                           en_q;
  logic [N_CHAN-1:0]              cblk_q;
  logic [N_CHAN-1:0]              pulse_q;
  logic [N_TRIG-1:0][N_CHAN-1:0]  imap_q;
  logic [N_TRIG-1:0][N_CHAN-1:0]  omap_q;
  logic [N_TRIG-1:0]              sync1_q, sync2_q;
  logic [N_CHAN-1:0]              chan_raw;
  logic [N_CHAN-1:0]              chan_all;
  logic [N_TRIG-1:0]              trig_nxt;
  logic                           addr_valid;
  logic                           pulse_wr;
  logic                           unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:N_CHAN];
  assign pulse_wr     = reg_we && (reg_addr == OFS_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= trig_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cblk_q <= '0;
      imap_q <= '0;
      omap_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == OFS_CTRL) en_q   <= reg_wdata[0];
      if (reg_addr == OFS_CBLK) cblk_q <= reg_wdata[N_CHAN-1:0];
      for (int i = 0; i < N_TRIG; i++) begin
        if (reg_addr == ADDR_W'(OFS_IMAP + 4*i)) imap_q[i] <= reg_wdata[N_CHAN-1:0];
        if (reg_addr == ADDR_W'(OFS_OMAP + 4*i)) omap_q[i] <= reg_wdata[N_CHAN-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_wr ? reg_wdata[N_CHAN-1:0] : '0;
  end

  always_comb begin
    reg_rdata  = '0;
    addr_valid = (reg_addr == OFS_CTRL) || (reg_addr == OFS_CBLK) || (reg_addr == OFS_PULSE);
    if (reg_addr == OFS_CTRL) reg_rdata[0] = en_q;
    if (reg_addr == OFS_CBLK) reg_rdata[N_CHAN-1:0] = cblk_q;
    for (int i = 0; i < N_TRIG; i++) begin
      if (reg_addr == ADDR_W'(OFS_IMAP + 4*i)) begin
        reg_rdata[N_CHAN-1:0] = imap_q[i];
        addr_valid = 1'b1;
      end
      if (reg_addr == ADDR_W'(OFS_OMAP + 4*i)) begin
        reg_rdata[N_CHAN-1:0] = omap_q[i];
        addr_valid = 1'b1;
      end
    end
  end

  always_comb begin
    chan_raw = pulse_q;
    for (int i = 0; i < N_TRIG; i++)
      chan_raw = chan_raw | ({N_CHAN{sync2_q[i]}} & imap_q[i]);
  end

  assign chan_out = chan_raw & ~cblk_q & {N_CHAN{en_q}};
  assign chan_all = chan_in | chan_out;

  genvar j;
  generate
    for (j = 0; j < N_TRIG; j++) begin : g_out
      assign trig_nxt[j] = en_q & (|(chan_all & omap_q[j]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_out <= '0;
    else        trig_out <= trig_nxt;
  end

  // R7
  chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> chan_out == '0);

  // R7
  trig_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> trig_out == '0);

  // R5
  map_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_CBLK) |=> ($stable(imap_q) && $stable(omap_q)));

  // R8
  undef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !addr_valid) |=> ($stable(imap_q) && $stable(omap_q) && $stable(cblk_q) && $stable(en_q)));

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0 && !pulse_wr) |=> pulse_q == '0);

endmodule

// File: tb/tb_dbg_xtrig_link.sv
module tb_dbg_xtrig_link;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_in = '0;
  logic [3:0]  chan_in = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  chan_out;
  logic [7:0]  trig_out;

  int n_run = 0;
  int n_fail = 0;

  dbg_xtrig_link dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .chan_in(chan_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .chan_out(chan_out), .trig_out(trig_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {trig_in, chan_in, expected chan_out, expected trig_out}
  localparam logic [23:0] VEC [9] = '{
    {8'h00, 4'h0, 4'h0, 8'h00},
    {8'h01, 4'h0, 4'h1, 8'h09},
    {8'h02, 4'h0, 4'h6, 8'h0E},
    {8'h04, 4'h0, 4'h8, 8'h0C},
    {8'h80, 4'h0, 4'h0, 8'h00},
    {8'h00, 4'h2, 4'h0, 8'h0A},
    {8'h05, 4'h0, 4'h9, 8'h0D},
    {8'hFF, 4'h0, 4'hF, 8'h0F},
    {8'h00, 4'h4, 4'h0, 8'h0C}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 chan_out", {28'h0, chan_out}, 32'h0);
    check("R1 trig_out", {24'h0, trig_out}, 32'h0);
    rd(8'h00, r); check("R1 CTRL", r, 32'h0);
    rd(8'h04, r); check("R1 CBLK", r, 32'h0);
    rd(8'h20, r); check("R1 IMAP0", r, 32'h0);
    rd(8'h5C, r); check("R1 OMAP7", r, 32'h0);

    wr(8'h00, 32'h1);
    wr(8'h20, 32'h1);
    wr(8'h24, 32'h6);
    wr(8'h28, 32'h8);
    wr(8'h40, 32'h1);
    wr(8'h44, 32'h2);
    wr(8'h48, 32'hC);
    wr(8'h4C, 32'hF);

    // R8 readback
    rd(8'h24, r); check("R8 IMAP1 readback", r, 32'h6);
    rd(8'h48, r); check("R8 OMAP2 readback", r, 32'hC);

    // R2 R3 mapping table
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      trig_in = VEC[k][23:16];
      chan_in = VEC[k][15:12];
      repeat (3) @(negedge clk);
      check($sformatf("R2 vec%0d chan_out", k), {28'h0, chan_out}, {28'h0, VEC[k][11:8]});
      check($sformatf("R3 vec%0d trig_out", k), {24'h0, trig_out}, {24'h0, VEC[k][7:0]});
    end
    trig_in = '0; chan_in = '0;
    repeat (4) @(negedge clk);

    // R4 latency
    trig_in = 8'h01;
    @(negedge clk);
    check("R4 edge1 chan_out", {28'h0, chan_out}, 32'h0);
    @(negedge clk);
    check("R4 edge2 chan_out", {28'h0, chan_out}, 32'h1);
    check("R4 edge2 trig_out", {24'h0, trig_out}, 32'h0);
    @(negedge clk);
    check("R4 edge3 trig_out", {24'h0, trig_out}, 32'h09);

    // R5 block channel 0
    wr(8'h04, 32'h1);
    @(negedge clk);
    check("R5 blocked chan_out", {28'h0, chan_out}, 32'h0);
    check("R5 blocked trig_out", {24'h0, trig_out}, 32'h0);
    rd(8'h20, r); check("R5 IMAP0 kept", r, 32'h1);
    rd(8'h40, r); check("R5 OMAP0 kept", r, 32'h1);
    wr(8'h04, 32'h0);
    trig_in = '0;
    repeat (4) @(negedge clk);

    // R6 one-cycle pulse
    wr(8'h08, 32'h4);
    check("R6 pulse chan_out", {28'h0, chan_out}, 32'h4);
    @(negedge clk);
    check("R6 pulse ends", {28'h0, chan_out}, 32'h0);
    check("R6 pulse trig_out", {24'h0, trig_out}, 32'h0C);
    @(negedge clk);
    check("R6 trig_out after", {24'h0, trig_out}, 32'h0);
    rd(8'h08, r); check("R6 pulse reads 0", r, 32'h0);
    wr(8'h04, 32'h4);
    wr(8'h08, 32'h4);
    check("R6 pulse blocked", {28'h0, chan_out}, 32'h0);
    wr(8'h04, 32'h0);

    // R8 undefined offsets
    wr(8'h0C, 32'hF);
    wr(8'h60, 32'hF);
    rd(8'h0C, r); check("R8 undef 0x0C reads 0", r, 32'h0);
    rd(8'h60, r); check("R8 undef 0x60 reads 0", r, 32'h0);
    rd(8'h00, r); check("R8 CTRL intact", r, 32'h1);
    rd(8'h04, r); check("R8 CBLK intact", r, 32'h0);
    rd(8'h24, r); check("R8 IMAP1 intact", r, 32'h6);

    // R7 global enable
    trig_in = 8'hFF;
    repeat (4) @(negedge clk);
    check("R7 enabled trig_out", {24'h0, trig_out}, 32'h0F);
    wr(8'h00, 32'h0);
    check("R7 chan_out off", {28'h0, chan_out}, 32'h0);
    @(negedge clk);
    check("R7 trig_out off", {24'h0, trig_out}, 32'h0);
    trig_in = '0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule